// File: doc/BRIEF.md
# Prioritised Interrupt Level Controller

This block gathers interrupt requests for levels 1 through 15 on behalf of one processor and presents the single most urgent one as a 4-bit level code, where code 0 stands for "nothing to service". Each level has three state bits: a pending bit, which peripherals set; a force bit, which software sets to raise an interrupt without any peripheral; and an enable bit in the mask register. A level competes for the output only when its pending or force bit is set and its enable bit is set. Level 15 is the exception: it reaches the output whatever its enable bit holds.

Software reaches the three registers through a simple single-cycle write port and a combinational read port that share one address. The processor reports each interrupt it takes on the acknowledge port together with the level it took. If the force bit of that level is set, the acknowledge clears the force bit and leaves the pending bit alone. Otherwise it clears the pending bit. Peripheral requests, acknowledges and register writes are all plain level-qualified control pins. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset the pending, force and enable registers all read zero and `irq_level` is 0.
- R2: Register address 0 selects pending, 1 selects force and 2 selects enable. A write replaces the whole selected register in one clock. `reg_rdata` shows the current contents of the addressed register in the same cycle. Address 3 reads zero and writes to it change nothing.
- R3: Bit 0 of every register reads zero and ignores writes, requests and acknowledges.
- R4: A high `periph_irq[i]` for i in 1..15 sets pending bit i at the next clock edge, and the bit stays set until it is cleared.
- R5: `irq_level` is the highest i in 1..15 whose pending or force bit is set and whose enable bit is set. It is 0 when no level qualifies, and it follows register changes in the same cycle.
- R6: Level 15 is presented whenever its pending or force bit is set, even when enable bit 15 is clear.
- R7: An acknowledge for level L whose force bit is set clears force bit L and leaves pending bit L unchanged.
- R8: An acknowledge for level L whose force bit is clear clears pending bit L.
- R9: When a peripheral request and an acknowledge target the same pending bit in the same cycle, that bit ends up set.
- R10: An acknowledge carrying level 0 changes no register.
- R11: When a write to the pending register and a peripheral request for the same bit fall in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| periph_irq | input | 16 | Peripheral request per level (bit 0 unused) |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for both read and write |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Contents of the addressed register |
| ack_valid | input | 1 | Processor acknowledge strobe |
| ack_level | input | 4 | Level being acknowledged |
| irq_level | output | 4 | Highest qualifying level, 0 when none |

## Verification
Three sources can change the same pending bit in a single clock: a peripheral request, an acknowledge and a register write. The force bit can also be hit by an acknowledge in the same cycle as a write. The table drives a request and an acknowledge for the same level on the same edge, and drives a pending write of zero together with a request for the same level. It then reads the pending register back and checks that the bit survived. A separate case acknowledges a level whose force and pending bits are both set, and the bench checks that only the force bit dropped while the output level stayed the same.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    SEL_PEND  = 2'd0,
    SEL_FORCE = 2'd1,
    SEL_MASK  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int NLVL = 16,
  localparam int LVLW = $clog2(NLVL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLVL-1:0] periph_irq,
  input  logic            wr_en,
  input  reg_sel_e        wr_sel,
  input  logic [NLVL-1:0] wdata,
  input  logic            ack_valid,
  input  logic [LVLW-1:0] ack_level,
  output logic [NLVL-1:0] pend_q,
  output logic [NLVL-1:0] force_q,
  output logic [NLVL-1:0] mask_q
);
  // bit 0 is never a real level
  localparam logic [NLVL-1:0] LEGAL = {{(NLVL-1){1'b1}}, 1'b0};

  logic [NLVL-1:0] ack_dec;
  logic [NLVL-1:0] clr_force, clr_pend;
  logic [NLVL-1:0] pend_d, force_d, mask_d;

  always_comb begin
    ack_dec   = ack_valid ? (NLVL'(1) << ack_level) : '0;
    // acknowledge consumes a forced request before a pending one
    clr_force = ack_dec & force_q;
    clr_pend  = ack_dec & ~force_q;

    pend_d  = (wr_en && wr_sel == SEL_PEND)  ? wdata : (pend_q & ~clr_pend);
    pend_d  = (pend_d | periph_irq) & LEGAL;
    force_d = (wr_en && wr_sel == SEL_FORCE) ? wdata : (force_q & ~clr_force);
    force_d = force_d & LEGAL;
    mask_d  = (wr_en && wr_sel == SEL_MASK)  ? wdata : mask_q;
    mask_d  = mask_d & LEGAL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= '0;
      force_q <= '0;
      mask_q  <= '0;
    end else begin
      pend_q  <= pend_d;
      force_q <= force_d;
      mask_q  <= mask_d;
    end
  end

  assert_req_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(periph_irq & LEGAL)) |=> ((pend_q & $past(periph_irq) & LEGAL) == ($past(periph_irq) & LEGAL)));

  assert_ack_force_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_level != '0 && force_q[ack_level] && !(wr_en && wr_sel == SEL_FORCE))
    |=> !force_q[$past(ack_level)]);

  assert_ack_keeps_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_level != '0 && force_q[ack_level] && !(wr_en && wr_sel == SEL_PEND))
    |=> (pend_q[$past(ack_level)] == ($past(pend_q[ack_level]) | $past(periph_irq[ack_level]))));

  assert_ack_clears_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_level != '0 && !force_q[ack_level] && !periph_irq[ack_level]
     && !(wr_en && wr_sel == SEL_PEND))
    |=> !pend_q[$past(ack_level)]);
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int NLVL = 16,
  localparam int LVLW = $clog2(NLVL)
) (
  input  logic [NLVL-1:0] req,
  input  logic [NLVL-1:0] enable,
  output logic [LVLW-1:0] level
);
  // the top level bypasses the enable bit
  localparam logic [NLVL-1:0] ALWAYS_ON = {1'b1, {(NLVL-1){1'b0}}};

  logic [NLVL-1:0] elig;
  logic [LVLW-1:0] chain [NLVL];

  assign elig     = req & (enable | ALWAYS_ON);
  assign chain[0] = '0;

  for (genvar g = 1; g < NLVL; g++) begin : g_casc
    assign chain[g] = elig[g] ? LVLW'(g) : chain[g-1];
  end

  assign level = chain[NLVL-1];
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irqc_pkg::*;
#(
  parameter int NLVL = 16,
  localparam int LVLW = $clog2(NLVL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLVL-1:0] periph_irq,
  input  logic            reg_wr_en,
  input  logic [1:0]      reg_addr,
  input  logic [NLVL-1:0] reg_wdata,
  output logic [NLVL-1:0] reg_rdata,
  input  logic            ack_valid,
  input  logic [LVLW-1:0] ack_level,
  output logic [LVLW-1:0] irq_level
);
  reg_sel_e        sel;
  logic [NLVL-1:0] pend_q, force_q, mask_q;

  assign sel = reg_sel_e'(reg_addr);

  irqc_regs #(.NLVL(NLVL)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .periph_irq(periph_irq),
    .wr_en     (reg_wr_en),
    .wr_sel    (sel),
    .wdata     (reg_wdata),
    .ack_valid (ack_valid),
    .ack_level (ack_level),
    .pend_q    (pend_q),
    .force_q   (force_q),
    .mask_q    (mask_q)
  );

  irqc_prio #(.NLVL(NLVL)) u_prio (
    .req   (pend_q | force_q),
    .enable(mask_q),
    .level (irq_level)
  );

  always_comb begin
    unique case (sel)
      SEL_PEND:  reg_rdata = pend_q;
      SEL_FORCE: reg_rdata = force_q;
      SEL_MASK:  reg_rdata = mask_q;
      default:   reg_rdata = '0;
    endcase
  end

  assert_bit0_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[0]);

  assert_level_has_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != '0) |-> (pend_q[irq_level] | force_q[irq_level]));

  assert_level_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != '0 && irq_level != LVLW'(NLVL-1)) |-> mask_q[irq_level]);

  assert_top_unmaskable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[NLVL-1] | force_q[NLVL-1]) |-> (irq_level == LVLW'(NLVL-1)));

  assert_nop_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_level == '0 && !reg_wr_en && periph_irq == '0)
    |=> $stable(pend_q) && $stable(force_q) && $stable(mask_q));
endmodule

// File: tb/irq_level_ctrl_bench.sv
module irq_level_ctrl_bench;
  typedef struct packed {
    logic        wr;
    logic [1:0]  waddr;
    logic [15:0] wdata;
    logic [15:0] periph;
    logic        ackv;
    logic [3:0]  ackl;
    logic [1:0]  raddr;
    logic [15:0] erd;
    logic [3:0]  elvl;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd2, 16'h00FE, 16'h0000, 1'b0, 4'd0,  2'd2, 16'h00FE, 4'd0,  4'd2},  // R2 mask write
    '{1'b0, 2'd0, 16'h0000, 16'h0008, 1'b0, 4'd0,  2'd0, 16'h0008, 4'd3,  4'd4},  // R4 request level 3
    '{1'b0, 2'd0, 16'h0000, 16'h0200, 1'b0, 4'd0,  2'd0, 16'h0208, 4'd3,  4'd5},  // R5 level 9 disabled
    '{1'b1, 2'd1, 16'h0020, 16'h0000, 1'b0, 4'd0,  2'd1, 16'h0020, 4'd5,  4'd5},  // R5 force level 5
    '{1'b0, 2'd0, 16'h0000, 16'h0000, 1'b1, 4'd5,  2'd1, 16'h0000, 4'd3,  4'd7},  // R7 ack forced 5
    '{1'b1, 2'd1, 16'h0008, 16'h0000, 1'b0, 4'd0,  2'd1, 16'h0008, 4'd3,  4'd2},  // R2 force 3 over pend 3
    '{1'b0, 2'd0, 16'h0000, 16'h0000, 1'b1, 4'd3,  2'd0, 16'h0208, 4'd3,  4'd7},  // R7 pend kept
    '{1'b0, 2'd0, 16'h0000, 16'h0000, 1'b1, 4'd3,  2'd0, 16'h0200, 4'd0,  4'd8},  // R8 pend cleared
    '{1'b0, 2'd0, 16'h0000, 16'h8000, 1'b0, 4'd0,  2'd0, 16'h8200, 4'd15, 4'd6},  // R6 top level unmasked
    '{1'b0, 2'd0, 16'h0000, 16'h0004, 1'b1, 4'd15, 2'd0, 16'h0204, 4'd2,  4'd8},  // R8 ack 15
    '{1'b0, 2'd0, 16'h0000, 16'h0004, 1'b1, 4'd2,  2'd0, 16'h0204, 4'd2,  4'd9},  // R9 request vs ack
    '{1'b1, 2'd0, 16'h0001, 16'h0000, 1'b0, 4'd0,  2'd0, 16'h0000, 4'd0,  4'd3},  // R3 bit 0 write
    '{1'b1, 2'd3, 16'hFFFF, 16'h0000, 1'b0, 4'd0,  2'd3, 16'h0000, 4'd0,  4'd2},  // R2 address 3
    '{1'b0, 2'd0, 16'h0000, 16'h0000, 1'b0, 4'd0,  2'd2, 16'h00FE, 4'd0,  4'd2},  // R2 mask untouched
    '{1'b1, 2'd0, 16'h0000, 16'h0010, 1'b0, 4'd0,  2'd0, 16'h0010, 4'd4,  4'd11}, // R11 write vs request
    '{1'b0, 2'd0, 16'h0000, 16'h0000, 1'b1, 4'd0,  2'd0, 16'h0010, 4'd4,  4'd10}, // R10 ack level 0
    '{1'b1, 2'd2, 16'hFFFE, 16'h0400, 1'b0, 4'd0,  2'd2, 16'hFFFE, 4'd10, 4'd5},  // R5 all enabled
    '{1'b1, 2'd1, 16'h4001, 16'h0000, 1'b0, 4'd0,  2'd1, 16'h4000, 4'd14, 4'd3}   // R3 force bit 0 dropped
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] periph_irq = '0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        ack_valid = 1'b0;
  logic [3:0]  ack_level = '0;
  logic [3:0]  irq_level;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_level_ctrl u_irq_level_ctrl (
    .clk(clk), .rst_n(rst_n), .periph_irq(periph_irq),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ack_valid(ack_valid), .ack_level(ack_level),
    .irq_level(irq_level)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    reg_wr_en  = 1'b0;
    reg_wdata  = '0;
    periph_irq = '0;
    ack_valid  = 1'b0;
    ack_level  = '0;
  endtask

  task automatic check_all_zero(input string tag);
    for (int a = 0; a < 3; a++) begin
      reg_addr = 2'(a);
      #1;
      chk(tag, reg_rdata, 16'h0000);
    end
    chk(tag, {12'h0, irq_level}, 16'h0000);
  endtask

  initial begin
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_all_zero("R1 reset");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      reg_wr_en  = VEC[i].wr;
      reg_addr   = VEC[i].waddr;
      reg_wdata  = VEC[i].wdata;
      periph_irq = VEC[i].periph;
      ack_valid  = VEC[i].ackv;
      ack_level  = VEC[i].ackl;
      @(negedge clk);
      idle_inputs();
      reg_addr = VEC[i].raddr;
      #1;
      chk($sformatf("R%0d vec %0d rdata", VEC[i].req, i), reg_rdata, VEC[i].erd);
      chk($sformatf("R%0d vec %0d level", VEC[i].req, i), {12'h0, irq_level}, {12'h0, VEC[i].elvl});
    end

    // R6: forced top level with enable bit 15 clear
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 2'd2; reg_wdata = 16'h0002;
    @(negedge clk);
    reg_addr = 2'd1; reg_wdata = 16'h8000;
    @(negedge clk);
    idle_inputs();
    #1;
    chk("R6 forced 15 unmasked", {12'h0, irq_level}, 16'd15);

    // R1: reset in mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    periph_irq = 16'hFFFF;
    @(negedge clk);
    periph_irq = '0;
    rst_n = 1'b1;
    #1;
    check_all_zero("R1 mid-run reset");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule